// File: doc/BRIEF.md
# Signed Long Multiply-Accumulate Unit

This unit multiplies two 32-bit two's complement operands and adds the result to a 64-bit signed accumulator. It returns the 64-bit sum as two 32-bit words. A two-bit mode input selects how the operands are read. The first choice treats each operand as one full signed word. The second multiplies a single signed halfword from each operand, and a separate select bit per operand picks that halfword. The third forms two signed halfword products, either straight or with the second operand's halfwords crossed. One 64-bit adder serves all of these.

A caller drives the operands, the accumulator words, the mode and the halfword selects, and pulses `start`. A small controller has three states. IDLE waits for work. CALC holds the captured operands while the product and sum settle. DONE presents the result with `done` high. There are three transitions. IDLE moves to CALC when `start` is seen. CALC always moves to DONE. DONE always returns to IDLE. The result words keep their value after DONE until the next result is written.

Top module: `wide_mac_unit`

## Requirements
- R1: While `rst_n` is low, `res_lo`, `res_hi` and `done` are all zero.
- R2: A `start` sampled in IDLE at clock edge E0 makes `done` high for exactly the one cycle that follows edge E0+1, and the result is valid in that cycle. `done` is low after edges E0 and E0+2. The result words change only when `done` rises, and otherwise hold their value.
- R3: A `start` that arrives while the unit is in CALC or DONE is ignored and does not change the pending result. A `start` held into the IDLE cycle right after DONE is accepted.
- R4: With `mode`=2'b00, the result is the accumulator plus the signed 64-bit product of `op_a` and `op_b`.
- R5: The accumulator and result are carried as two words. The low word holds bits [31:0] and the high word holds bits [63:32], so a carry out of the low word reaches the high word.
- R6: With `mode`=2'b01, `hsel[0]` picks the halfword of `op_a` and `hsel[1]` picks the halfword of `op_b`. The value 0 picks bits [15:0] and the value 1 picks bits [31:16]. The unit multiplies the two picked halfwords as signed values and adds the product to the accumulator. All four combinations of the select bits are supported.
- R7: With `mode`=2'b01, the 32-bit product is sign-extended to 64 bits before it is added, so a negative product lowers the high word.
- R8: With `mode`=2'b01, the halfwords that were not picked have no effect on the result.
- R9: With `mode`=2'b10, the result is the accumulator plus top(a)×top(b) plus bottom(a)×bottom(b). Each product is a signed halfword product that is sign-extended to 64 bits.
- R10: With `mode`=2'b11, the result is the accumulator plus top(a)×bottom(b) plus bottom(a)×top(b), with the same signed, sign-extended products.
- R11: All additions wrap modulo 2^64. There is no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation (taken only in IDLE) |
| mode | input | 2 | 00 full word, 01 single halfword, 10 dual, 11 dual crossed |
| hsel | input | 2 | Halfword selects for mode 01: bit 0 for op_a, bit 1 for op_b, 1 = top |
| op_a | input | 32 | First signed operand |
| op_b | input | 32 | Second signed operand |
| acc_lo | input | 32 | Accumulator bits [31:0] |
| acc_hi | input | 32 | Accumulator bits [63:32] |
| res_lo | output | 32 | Result bits [31:0] |
| res_hi | output | 32 | Result bits [63:32] |
| done | output | 1 | One-cycle flag that marks a valid new result |

## Verification
The bench sweeps a grid of edge operands in every mode, with every select combination and several accumulator patterns. The operands include 0x80000000 squared, all ones, and words whose top and bottom halfwords differ in sign. Each case has its own purpose:
- A design that multiplies unsigned would give the wrong high word for all-ones operands.
- A design that zero-extends the halfword product would fail when the product is negative.
- A design that leaves out the carry between the words would fail when the accumulator is 0x00000000_FFFFFFFF.
- An accumulator of all ones checks the wraparound past 2^64.

Further cases cover the other rules:
- Operands whose unpicked halfwords hold junk expose any leak from unselected halves.
- A swap of the crossed and straight dual pairs shows up as wrong sums.
- A `start` held high through CALC and DONE catches a controller that restarts early or overwrites the pending result.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

    typedef enum logic [1:0] {
        MODE_WORD  = 2'b00,
        MODE_HALF  = 2'b01,
        MODE_DUAL  = 2'b10,
        MODE_DUALX = 2'b11
    } wmac_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CALC = 2'b01,
        ST_DONE = 2'b10
    } wmac_state_e;

endpackage

// File: rtl/wmac_opsel.sv
// Picks the halfword pairs for the two product lanes based on the mode.
module wmac_opsel
    import wmac_pkg::*;
#(
    parameter int OPW = 32,
    localparam int HW = OPW / 2
) (
    input  wmac_mode_e          mode,
    input  logic [1:0]          hsel,
    input  logic [OPW-1:0]      a,
    input  logic [OPW-1:0]      b,
    output logic [1:0][HW-1:0]  lane_x,
    output logic [1:0][HW-1:0]  lane_y,
    output logic [1:0]          lane_en
);
    logic [HW-1:0] a_top, a_bot, b_top, b_bot;

    always_comb begin
        a_top   = a[OPW-1:HW];
        a_bot   = a[HW-1:0];
        b_top   = b[OPW-1:HW];
        b_bot   = b[HW-1:0];
        lane_x  = '0;
        lane_y  = '0;
        lane_en = 2'b00;
        unique case (mode)
            MODE_WORD: begin
                lane_en = 2'b00;
            end
            MODE_HALF: begin
                lane_x[0] = hsel[0] ? a_top : a_bot;
                lane_y[0] = hsel[1] ? b_top : b_bot;
                lane_en   = 2'b01;
            end
            MODE_DUAL: begin
                lane_x[0] = a_bot;
                lane_y[0] = b_bot;
                lane_x[1] = a_top;
                lane_y[1] = b_top;
                lane_en   = 2'b11;
            end
            MODE_DUALX: begin
                lane_x[0] = a_bot;
                lane_y[0] = b_top;
                lane_x[1] = a_top;
                lane_y[1] = b_bot;
                lane_en   = 2'b11;
            end
            default: begin
                lane_en = 2'b00;
            end
        endcase
    end
endmodule

// File: rtl/wmac_mult.sv
// Full-word signed product plus two signed halfword lanes, each widened to the accumulator width.
module wmac_mult #(
    parameter int OPW = 32,
    localparam int HW   = OPW / 2,
    localparam int ACCW = 2 * OPW,
    localparam int LANES = 2
) (
    input  logic [OPW-1:0]            a,
    input  logic [OPW-1:0]            b,
    input  logic [LANES-1:0][HW-1:0]  lane_x,
    input  logic [LANES-1:0][HW-1:0]  lane_y,
    input  logic [LANES-1:0]          lane_en,
    output logic [ACCW-1:0]           full_p,
    output logic [LANES-1:0][ACCW-1:0] lane_p
);
    logic signed [ACCW-1:0] fa, fb;

    assign fa     = {{OPW{a[OPW-1]}}, a};
    assign fb     = {{OPW{b[OPW-1]}}, b};
    assign full_p = fa * fb;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [OPW-1:0] xs, ys, p;
        assign xs = {{HW{lane_x[g][HW-1]}}, lane_x[g]};
        assign ys = {{HW{lane_y[g][HW-1]}}, lane_y[g]};
        assign p  = xs * ys;
        assign lane_p[g] = lane_en[g] ? {{OPW{p[OPW-1]}}, p} : '0;
    end
endmodule

// File: rtl/wmac_sum.sv
// Single wrapping accumulator adder shared by every mode.
module wmac_sum
    import wmac_pkg::*;
#(
    parameter int OPW = 32,
    localparam int ACCW = 2 * OPW
) (
    input  wmac_mode_e            mode,
    input  logic [ACCW-1:0]       acc,
    input  logic [ACCW-1:0]       full_p,
    input  logic [1:0][ACCW-1:0]  lane_p,
    output logic [ACCW-1:0]       sum
);
    logic [ACCW-1:0] term;

    always_comb begin
        if (mode == MODE_WORD) begin
            term = full_p;
        end else begin
            term = lane_p[0] + lane_p[1];
        end
        sum = acc + term;
    end
endmodule

// File: rtl/wide_mac_unit.sv
module wide_mac_unit
    import wmac_pkg::*;
#(
    parameter int OPW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     mode,
    input  logic [1:0]     hsel,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    input  logic [OPW-1:0] acc_lo,
    input  logic [OPW-1:0] acc_hi,
    output logic [OPW-1:0] res_lo,
    output logic [OPW-1:0] res_hi,
    output logic           done
);
    localparam int HW   = OPW / 2;
    localparam int ACCW = 2 * OPW;

    wmac_state_e state_q, state_d;
    logic        accept;

    logic [OPW-1:0]  a_q, b_q;
    logic [ACCW-1:0] acc_q;
    wmac_mode_e      mode_q;
    logic [1:0]      hsel_q;
    logic [ACCW-1:0] res_q;

    logic [1:0][HW-1:0]   lane_x, lane_y;
    logic [1:0]           lane_en;
    logic [ACCW-1:0]      full_p;
    logic [1:0][ACCW-1:0] lane_p;
    logic [ACCW-1:0]      sum_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CALC;
            ST_CALC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            mode_q <= MODE_WORD;
            hsel_q <= '0;
        end else if (accept) begin
            a_q    <= op_a;
            b_q    <= op_b;
            acc_q  <= {acc_hi, acc_lo};
            mode_q <= wmac_mode_e'(mode);
            hsel_q <= hsel;
        end
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   res_q <= '0;
        else if (state_q == ST_CALC)  res_q <= sum_d;
    end

    // outputs
    always_comb begin
        done   = (state_q == ST_DONE);
        res_lo = res_q[OPW-1:0];
        res_hi = res_q[ACCW-1:OPW];
    end

    wmac_opsel #(.OPW(OPW)) u_opsel (
        .mode    (mode_q),
        .hsel    (hsel_q),
        .a       (a_q),
        .b       (b_q),
        .lane_x  (lane_x),
        .lane_y  (lane_y),
        .lane_en (lane_en)
    );

    wmac_mult #(.OPW(OPW)) u_mult (
        .a       (a_q),
        .b       (b_q),
        .lane_x  (lane_x),
        .lane_y  (lane_y),
        .lane_en (lane_en),
        .full_p  (full_p),
        .lane_p  (lane_p)
    );

    wmac_sum #(.OPW(OPW)) u_sum (
        .mode   (mode_q),
        .acc    (acc_q),
        .full_p (full_p),
        .lane_p (lane_p),
        .sum    (sum_d)
    );
endmodule

// File: rtl/wmac_checker.sv
module wmac_checker
    import wmac_pkg::*;
#(
    parameter int OPW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic [1:0]     state,
    input logic [OPW-1:0] res_lo,
    input logic [OPW-1:0] res_hi
);
    // R1: outputs cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (done == 1'b0 && res_lo == '0 && res_hi == '0)
                else $error("reset state not clear");
        end
    end

    // R2: done lasts a single cycle
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done comes two edges after an accepted start
    assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));

    // R2: result words move only together with done
    assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_hi, res_lo}) |-> done);

    // R3: no new calculation begins from a busy state
    assert_busy_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_CALC));

    // R3: start in IDLE is always taken
    assert_idle_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_CALC));
endmodule

bind wide_mac_unit wmac_checker #(.OPW(OPW)) u_wmac_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .state  (state_q),
    .res_lo (res_lo),
    .res_hi (res_hi)
);

// File: tb/wide_mac_unit_bench.sv
module wide_mac_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  mode;
    logic [1:0]  hsel;
    logic [31:0] op_a, op_b, acc_lo, acc_hi;
    logic [31:0] res_lo, res_hi;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wide_mac_unit u_wide_mac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .hsel(hsel),
        .op_a(op_a), .op_b(op_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .res_lo(res_lo), .res_hi(res_hi), .done(done)
    );

    function automatic logic [63:0] ref_mac(input logic [1:0] m, input logic [1:0] hs,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [63:0] acc);
        logic signed [15:0] ah, al, bh, bl, x, y;
        logic signed [31:0] sa, sb;
        logic signed [63:0] p;
        ah = a[31:16]; al = a[15:0]; bh = b[31:16]; bl = b[15:0];
        sa = a; sb = b;
        case (m)
            2'b00: p = 64'(sa) * 64'(sb);
            2'b01: begin
                x = hs[0] ? ah : al;
                y = hs[1] ? bh : bl;
                p = 64'(x) * 64'(y);
            end
            2'b10: p = 64'(ah) * 64'(bh) + 64'(al) * 64'(bl);
            default: p = 64'(ah) * 64'(bl) + 64'(al) * 64'(bh);
        endcase
        return acc + p;
    endfunction

    function automatic logic [31:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h0001_8000;
            6: return 32'h8000_FFFF;
            default: return 32'h1234_F678;
        endcase
    endfunction

    function automatic logic [63:0] acc_pat(input int i);
        case (i)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h7FFF_FFFF_FFFF_FFFF;
            default: return 64'h0000_0000_FFFF_FFFF;
        endcase
    endfunction

    task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check1(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Called at a point 1ns after a rising edge with the unit in IDLE.
    task automatic run_op(input string tag, input logic [1:0] m, input logic [1:0] hs,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] acc, output logic [63:0] got);
        logic [63:0] exp;
        exp = ref_mac(m, hs, a, b, acc);
        mode = m; hsel = hs; op_a = a; op_b = b;
        acc_lo = acc[31:0]; acc_hi = acc[63:32];
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        op_a = ~a; op_b = ~b;
        check1("R2 done low in CALC", done, 1'b0);
        @(posedge clk); #1;
        check1("R2 done high", done, 1'b1);
        got = {res_hi, res_lo};
        check64(tag, got, exp);
        @(posedge clk); #1;
        check1("R2 done low after", done, 1'b0);
        check64("R2 result held", {res_hi, res_lo}, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] r, r2, exp;
        rst_n = 1'b0; start = 1'b0; mode = 2'b00; hsel = 2'b00;
        op_a = '0; op_b = '0; acc_lo = '0; acc_hi = '0;
        repeat (3) @(posedge clk);
        #1;
        check1("R1 done in reset", done, 1'b0);
        check64("R1 result in reset", {res_hi, res_lo}, 64'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R4: most negative squared
        run_op("R4 min squared", 2'b00, 2'b00, 32'h8000_0000, 32'h8000_0000, 64'h0, r);
        check64("R4 min squared value", r, 64'h4000_0000_0000_0000);
        // R4: all ones times all ones
        run_op("R4 ones", 2'b00, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0, r);
        check64("R4 ones value", r, 64'h1);
        // R5: carry from low word into high word
        run_op("R5 carry", 2'b00, 2'b00, 32'h1, 32'h1, 64'h0000_0000_FFFF_FFFF, r);
        check64("R5 carry value", r, 64'h0000_0001_0000_0000);
        // R11: wrap past 2^64
        run_op("R11 wrap", 2'b00, 2'b00, 32'h1, 32'h1, 64'hFFFF_FFFF_FFFF_FFFF, r);
        check64("R11 wrap value", r, 64'h0);
        run_op("R11 wrap positive", 2'b10, 2'b00, 32'h0001_0001, 32'h0001_0001,
               64'h7FFF_FFFF_FFFF_FFFF, r);
        check64("R11 wrap positive value", r, 64'h8000_0000_0000_0001);
        // R7: negative halfword product sign-extended
        run_op("R7 sign extend", 2'b01, 2'b00, 32'h0000_FFFF, 32'h0000_0001, 64'h0, r);
        check64("R7 sign extend value", r, 64'hFFFF_FFFF_FFFF_FFFF);
        // R8: unpicked halves do not matter
        run_op("R8 clean", 2'b01, 2'b10, 32'h0000_0003, 32'h0005_0000, 64'h10, r);
        run_op("R8 junk", 2'b01, 2'b10, 32'hABCD_0003, 32'h0005_9876, 64'h10, r2);
        check64("R8 junk equals clean", r2, r);
        check64("R8 value", r, 64'h1F);
        // R9 / R10 direct values
        run_op("R9 dual", 2'b10, 2'b00, 32'h0002_0003, 32'h0005_0007, 64'h0, r);
        check64("R9 dual value", r, 64'd31);
        run_op("R10 cross", 2'b11, 2'b00, 32'h0002_0003, 32'h0005_0007, 64'h0, r);
        check64("R10 cross value", r, 64'd29);

        // Sweep over operand corners, modes and selects
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int hs = 0; hs < 4; hs++) begin
                        if (m != 1 && hs != ((ia ^ ib) & 3)) continue;
                        case (m)
                            0: run_op("R4 sweep", 2'(m), 2'(hs), corner(ia), corner(ib),
                                      acc_pat((ia + ib) % 4), r);
                            1: run_op("R6 sweep", 2'(m), 2'(hs), corner(ia), corner(ib),
                                      acc_pat((ia + ib) % 4), r);
                            2: run_op("R9 sweep", 2'(m), 2'(hs), corner(ia), corner(ib),
                                      acc_pat((ia + ib) % 4), r);
                            default: run_op("R10 sweep", 2'(m), 2'(hs), corner(ia), corner(ib),
                                      acc_pat((ia + ib) % 4), r);
                        endcase
                    end
                end
            end
        end

        // R3: start held through CALC and DONE with different operands
        exp = ref_mac(2'b00, 2'b00, 32'd6, 32'd7, 64'h0);
        mode = 2'b00; hsel = 2'b00; op_a = 32'd6; op_b = 32'd7; acc_lo = '0; acc_hi = '0;
        start = 1'b1;
        @(posedge clk); #1;
        op_a = 32'd100; op_b = 32'd3; acc_lo = 32'd1;
        @(posedge clk); #1;
        check1("R3 done first", done, 1'b1);
        check64("R3 first result kept", {res_hi, res_lo}, exp);
        @(posedge clk); #1;
        check1("R3 no restart from DONE", done, 1'b0);
        check64("R3 result held", {res_hi, res_lo}, exp);
        @(posedge clk); #1;
        start = 1'b0;
        check1("R3 accepted after done", done, 1'b0);
        @(posedge clk); #1;
        check1("R3 second done", done, 1'b1);
        check64("R3 second result", {res_hi, res_lo}, 64'd301);
        @(posedge clk); #1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule